// File: doc/BRIEF.md
# In-Order Triplet Retirement Buffer

This block is the retirement end of an out-of-order core. Micro-operations arrive at it in groups of up to three, in program order, and each group is given one slot of a circular buffer. Execution units then report results by slot index and lane, in any order. The block releases the oldest group only when every occupied lane of that group has a result. It releases at most one whole group per clock and presents the group's three results with per-lane valid flags, so the architectural state only ever sees final results, in program order.

A slot may be partly filled. Each lane carries an occupancy bit, and an unoccupied lane counts as finished. A result arriving in the same cycle as the last missing lane of the oldest group is forwarded straight to the retire output, so that group leaves the buffer in that cycle. The buffer refuses new groups while it is full. The retire output stays idle while the buffer is empty.

Top module: `triplet_retire_buffer`

## Requirements
- R1: After reset `empty_o`=1, `full_o`=0, `alloc_ready_o`=1, `ret_valid_o`=0, and the retire lane flags and data are all zero.
- R2: An accepted allocation (`alloc_valid_i` and `alloc_ready_o`) takes the slot numbered `alloc_idx_o`. Slots are handed out in ascending order modulo GROUPS (default 8). `alloc_lanes_i` bit k marks lane k as occupied.
- R3: With GROUPS slots occupied, `full_o`=1 and `alloc_ready_o`=0. An allocation request in that state is dropped: it does not change the occupancy and does not retire later.
- R4: A writeback (`wb_valid_i`, slot `wb_group_i`, lane `wb_lane_i`, 0..2) marks that occupied lane finished and stores `wb_data_i`. Writebacks may come in any order.
- R5: The oldest group retires only when each occupied lane is finished. Until then `ret_valid_o`=0.
- R6: Groups retire strictly in allocation order. A younger group whose lanes are all finished waits behind an unfinished older group.
- R7: At most one group retires per clock. On retirement the occupancy drops by one and the slot is released for reuse.
- R8: An unoccupied lane counts as finished. At retirement its `ret_lane_valid_o` bit is 0 and its 16-bit field of `ret_data_o` (lane k at bits 16k+15..16k) is zero. A group with no occupied lanes retires with no writeback.
- R9: A writeback to the last missing lane of the oldest group retires that group in the same cycle, with `wb_data_i` on that lane's field.
- R10: A writeback to an unoccupied lane, to lane 3, or to a slot that holds no group is ignored. It neither finishes anything nor changes retired data.
- R11: When the buffer is empty, `ret_valid_o`=0, even when a writeback arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Request to enter a new group |
| alloc_lanes_i | input | 3 | Occupied lanes of the new group |
| alloc_ready_o | output | 1 | Allocation is accepted this cycle |
| alloc_idx_o | output | 3 | Slot index the new group receives |
| wb_valid_i | input | 1 | Execution result valid |
| wb_group_i | input | 3 | Slot index of the result |
| wb_lane_i | input | 2 | Lane of the result |
| wb_data_i | input | 16 | Result value |
| ret_valid_o | output | 1 | A group retires this cycle |
| ret_group_o | output | 3 | Slot index of the retiring group |
| ret_lane_valid_o | output | 3 | Occupied lanes of the retiring group |
| ret_data_o | output | 48 | Results of the retiring group, lane k at 16k |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |

## Verification
The bench drives these corner cases:
- A younger group finished before an older one. A design that ignored age would retire it early.
- The last result of the oldest group arriving in its retire cycle. A design without the forward would lose a cycle or retire a stale value.
- Groups with one or no occupied lanes. These would hang a design that waited on every lane.
- Results aimed at empty lanes or freed slots. These would corrupt a later group that reuses the slot.

Filling all eight slots and then requesting once more catches an overrun of the tail pointer. A long random phase, compared every clock against a queue model, checks that no cycle ever releases two groups or skips one.

// File: rtl/trb_pkg.sv
package trb_pkg;
  // A lane no longer blocks retirement if it is empty, already done,
  // or being written back in this very cycle.
  function automatic logic lane_clear(input logic occupied, input logic done, input logic hit);
    return !occupied || done || hit;
  endfunction

  // Occupancy of a circular buffer whose pointers carry one wrap bit.
  function automatic logic [7:0] ring_used(input logic [7:0] tail, input logic [7:0] head,
                                           input logic [7:0] mask);
    return (tail - head) & mask;
  endfunction
endpackage

// File: rtl/trb_ptrs.sv
module trb_ptrs #(
  parameter int GROUPS = 8,
  localparam int PW = $clog2(GROUPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  input  logic          ret_fire,
  output logic [PW-1:0] head_idx,
  output logic [PW-1:0] tail_idx,
  output logic          full,
  output logic          empty,
  output logic          alloc_fire
);
  import trb_pkg::*;
  localparam logic [7:0] WRAP_MASK = 8'((1 << (PW + 1)) - 1);
  localparam logic [7:0] CAP       = 8'(GROUPS);

  logic [PW:0] head_q, tail_q;
  logic [7:0]  used;

  assign used       = ring_used(8'(tail_q), 8'(head_q), WRAP_MASK);
  assign full       = (used == CAP);
  assign empty      = (used == 8'd0);
  assign alloc_fire = alloc_req && !full;
  assign head_idx   = head_q[PW-1:0];
  assign tail_idx   = tail_q[PW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (alloc_fire) tail_q <= tail_q + 1'b1;
      if (ret_fire)   head_q <= head_q + 1'b1;
    end
  end

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && alloc_req) |=> (tail_q == $past(tail_q))); // R3
  AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_fire && !alloc_fire) |=> (used == $past(used) - 8'd1)); // R7
  AST_NO_RETIRE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !ret_fire); // R11
endmodule

// File: rtl/trb_slots.sv
module trb_slots #(
  parameter int GROUPS = 8,
  parameter int LANES  = 3,
  parameter int DATA_W = 16,
  localparam int PW    = $clog2(GROUPS),
  localparam int LW    = $clog2(LANES + 1),
  localparam int SLOTS = GROUPS * LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_fire,
  input  logic [PW-1:0]           alloc_idx,
  input  logic [LANES-1:0]        alloc_lanes,
  input  logic                    wb_valid,
  input  logic [PW-1:0]           wb_group,
  input  logic [LW-1:0]           wb_lane,
  input  logic [DATA_W-1:0]       wb_data,
  input  logic                    ret_fire,
  input  logic [PW-1:0]           head_idx,
  output logic [LANES-1:0]        head_valid,
  output logic [LANES-1:0]        head_clear,
  output logic [LANES*DATA_W-1:0] head_data
);
  import trb_pkg::*;

  logic [SLOTS-1:0]  valid_q, done_q;
  logic [DATA_W-1:0] data_q [SLOTS];

  function automatic logic [LANES-1:0] group_valid(input logic [PW-1:0] g);
    logic [LANES-1:0] v;
    for (int l = 0; l < LANES; l++) v[l] = valid_q[int'(g) * LANES + l];
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      done_q  <= '0;
      for (int s = 0; s < SLOTS; s++) data_q[s] <= '0;
    end else begin
      for (int g = 0; g < GROUPS; g++) begin
        for (int l = 0; l < LANES; l++) begin
          if (alloc_fire && alloc_idx == PW'(g)) begin
            valid_q[g*LANES+l] <= alloc_lanes[l];
            done_q[g*LANES+l]  <= 1'b0;
          end else if (ret_fire && head_idx == PW'(g)) begin
            valid_q[g*LANES+l] <= 1'b0;
            done_q[g*LANES+l]  <= 1'b0;
          end else if (wb_valid && wb_group == PW'(g) && wb_lane == LW'(l)
                       && valid_q[g*LANES+l]) begin
            done_q[g*LANES+l] <= 1'b1;
            data_q[g*LANES+l] <= wb_data;
          end
        end
      end
    end
  end

  logic [LANES-1:0] head_hit;
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      head_valid[l] = valid_q[int'(head_idx) * LANES + l];
      head_hit[l]   = wb_valid && wb_group == head_idx && wb_lane == LW'(l);
      head_clear[l] = lane_clear(head_valid[l], done_q[int'(head_idx) * LANES + l], head_hit[l]);
      if (!head_valid[l])
        head_data[l*DATA_W +: DATA_W] = '0;
      else if (done_q[int'(head_idx) * LANES + l])
        head_data[l*DATA_W +: DATA_W] = data_q[int'(head_idx) * LANES + l];
      else
        head_data[l*DATA_W +: DATA_W] = wb_data;
    end
  end

  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (group_valid($past(head_idx)) == '0)); // R7
endmodule

// File: rtl/triplet_retire_buffer.sv
module triplet_retire_buffer #(
  parameter int GROUPS = 8,
  parameter int LANES  = 3,
  parameter int DATA_W = 16,
  localparam int PW    = $clog2(GROUPS),
  localparam int LW    = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_valid_i,
  input  logic [LANES-1:0]        alloc_lanes_i,
  output logic                    alloc_ready_o,
  output logic [PW-1:0]           alloc_idx_o,
  input  logic                    wb_valid_i,
  input  logic [PW-1:0]           wb_group_i,
  input  logic [LW-1:0]           wb_lane_i,
  input  logic [DATA_W-1:0]       wb_data_i,
  output logic                    ret_valid_o,
  output logic [PW-1:0]           ret_group_o,
  output logic [LANES-1:0]        ret_lane_valid_o,
  output logic [LANES*DATA_W-1:0] ret_data_o,
  output logic                    full_o,
  output logic                    empty_o
);
  logic [PW-1:0]           head_idx, tail_idx;
  logic                    full, empty, alloc_fire, ret_fire;
  logic [LANES-1:0]        head_valid, head_clear;
  logic [LANES*DATA_W-1:0] head_data;

  trb_ptrs #(.GROUPS(GROUPS)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_valid_i), .ret_fire(ret_fire),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full), .empty(empty),
    .alloc_fire(alloc_fire)
  );

  trb_slots #(.GROUPS(GROUPS), .LANES(LANES), .DATA_W(DATA_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire), .alloc_idx(tail_idx),
    .alloc_lanes(alloc_lanes_i), .wb_valid(wb_valid_i), .wb_group(wb_group_i),
    .wb_lane(wb_lane_i), .wb_data(wb_data_i), .ret_fire(ret_fire),
    .head_idx(head_idx), .head_valid(head_valid), .head_clear(head_clear),
    .head_data(head_data)
  );

  assign ret_fire         = !empty && (&head_clear);
  assign ret_valid_o      = ret_fire;
  assign ret_group_o      = head_idx;
  assign ret_lane_valid_o = ret_fire ? head_valid : '0;
  assign ret_data_o       = ret_fire ? head_data : '0;
  assign alloc_ready_o    = !full;
  assign alloc_idx_o      = tail_idx;
  assign full_o           = full;
  assign empty_o          = empty;

  AST_HEAD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !(&head_clear)) |=> ($stable(head_idx))); // R5
  AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (head_idx == $past(head_idx) + 1'b1)); // R6
endmodule

// File: tb/triplet_retire_buffer_tb.sv
`timescale 1ns/1ps
module triplet_retire_buffer_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        alloc_valid_i = 0;
  logic [2:0]  alloc_lanes_i = 0;
  logic        alloc_ready_o;
  logic [2:0]  alloc_idx_o;
  logic        wb_valid_i = 0;
  logic [2:0]  wb_group_i = 0;
  logic [1:0]  wb_lane_i = 0;
  logic [15:0] wb_data_i = 0;
  logic        ret_valid_o;
  logic [2:0]  ret_group_o;
  logic [2:0]  ret_lane_valid_o;
  logic [47:0] ret_data_o;
  logic        full_o, empty_o;

  always #4 clk = ~clk;

  triplet_retire_buffer u_dut (.*);

  int checks = 0, errors = 0;
  string cur = "R1";
  bit mvalid [8][3];
  bit mdone  [8][3];
  int mdata  [8][3];
  int mhead = 0, mcount = 0;
  int retired = 0;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  task automatic step(bit av, bit [2:0] al, bit wv, int wg, int wl, int wd);
    bit ev, ef, ee;
    bit [2:0] elanes;
    bit [47:0] edata;
    int tail;
    alloc_valid_i = av; alloc_lanes_i = al;
    wb_valid_i = wv; wb_group_i = 3'(wg); wb_lane_i = 2'(wl); wb_data_i = 16'(wd);
    #1;
    ef = (mcount == 8); ee = (mcount == 0);
    tail = (mhead + mcount) % 8;
    ev = !ee;
    for (int l = 0; l < 3; l++)
      if (mvalid[mhead][l] && !mdone[mhead][l] && !(wv && wg == mhead && wl == l)) ev = 0;
    elanes = 0; edata = 0;
    if (ev)
      for (int l = 0; l < 3; l++)
        if (mvalid[mhead][l]) begin
          elanes[l] = 1;
          edata[l*16 +: 16] = mdone[mhead][l] ? 16'(mdata[mhead][l]) : 16'(wd);
        end
    chk("full", full_o, ef);
    chk("empty", empty_o, ee);
    chk("alloc_ready", alloc_ready_o, !ef);
    chk("alloc_idx", alloc_idx_o, tail);
    chk("ret_valid", ret_valid_o, ev);
    chk("ret_lanes", ret_lane_valid_o, elanes);
    chk("ret_data", ret_data_o, edata);
    if (ev) chk("ret_group", ret_group_o, mhead);
    @(posedge clk);
    if (wv && wl < 3 && mvalid[wg][wl]) begin mdone[wg][wl] = 1; mdata[wg][wl] = wd & 16'hffff; end
    if (ev) begin
      for (int l = 0; l < 3; l++) begin mvalid[mhead][l] = 0; mdone[mhead][l] = 0; end
      mhead = (mhead + 1) % 8; mcount--; retired++;
    end
    if (av && !ef) begin
      for (int l = 0; l < 3; l++) begin mvalid[tail][l] = al[l]; mdone[tail][l] = 0; end
      mcount++;
    end
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur = "R1"; idle();

    // R2 R4 R6: three full groups, younger finishes first
    cur = "R2"; step(1, 3'b111, 0, 0, 0, 0); step(1, 3'b111, 0, 0, 0, 0); step(1, 3'b111, 0, 0, 0, 0);
    cur = "R6";
    step(0, 0, 1, 1, 2, 'h12); step(0, 0, 1, 1, 0, 'h10); step(0, 0, 1, 1, 1, 'h11);
    cur = "R4"; step(0, 0, 1, 0, 1, 'h01); step(0, 0, 1, 0, 0, 'h00);
    // R9: last lane of head arrives, group 0 retires same cycle
    cur = "R9"; step(0, 0, 1, 0, 2, 'h02);
    cur = "R7"; idle();                       // group 1 retires alone
    cur = "R5"; idle(); step(0, 0, 1, 2, 0, 'h20); step(0, 0, 1, 2, 2, 'h22);
    cur = "R9"; step(0, 0, 1, 2, 1, 'h21);
    cur = "R11"; step(0, 0, 1, 3, 0, 'h55); idle();

    // R8: partial and empty groups
    cur = "R8"; step(1, 3'b010, 0, 0, 0, 0); step(1, 3'b000, 0, 0, 0, 0);
    idle(); step(0, 0, 1, 3, 1, 'hbeef); idle(); idle();

    // R10: writes to an empty lane, lane 3, and a free slot
    cur = "R10"; step(1, 3'b101, 0, 0, 0, 0);
    step(0, 0, 1, 5, 1, 'hdead); step(0, 0, 1, 5, 3, 'hdead); step(0, 0, 1, 7, 0, 'hdead);
    step(0, 0, 1, 5, 0, 'h50); step(0, 0, 1, 5, 2, 'h52); idle();

    // R3: fill all slots, then one more request
    cur = "R3";
    for (int i = 0; i < 8; i++) step(1, 3'b001, 0, 0, 0, 0);
    step(1, 3'b111, 0, 0, 0, 0); step(1, 3'b111, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 1, (mhead + i) % 8, 0, 'h300 + i);
    idle(); idle();

    // R6 R7: random traffic against the model
    cur = "R6";
    for (int c = 0; c < 4000; c++) begin
      int g, l;
      g = (mhead + $urandom_range(0, 8)) % 8; l = $urandom_range(0, 2);
      r0 = $urandom_range(0, 3);
      step(r0 != 0, 3'($urandom_range(0, 7)), $urandom_range(0, 2) != 0, g, l, $urandom_range(0, 65535));
    end
    for (int c = 0; c < 40; c++) begin
      int g, l;
      g = (mhead) % 8; l = c % 3;
      step(0, 0, 1, g, l, c);
    end
    cur = "R7"; chk("retired some groups", retired > 100, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule